// File: doc/BRIEF.md
# Variable-Latency Speculative Booth Multiplier

This block multiplies two signed N-bit operands and returns the full 2N-bit product. Radix-4 Booth recoding turns the multiplier operand into N/2 partial-product rows. The row array is cut at column N-Z. The narrow low part (N-Z columns) and the wide high part (N+Z columns) are summed side by side. The high part does not wait for the low part's carry. Instead it adds a carry estimate taken from a short window of low-part columns.

When the estimate equals the true carry, the speculative product is final and appears one cycle after the operands are accepted. When the estimate is short, one correction cycle adds the missing carry into the high part. The result then appears two cycles after acceptance.

Operands and results each use a valid/ready handshake. A flag sent with each result tells whether the fast path was taken. The controller has four states:

- ST_IDLE: ready for operands.
- ST_SPEC_OUT: speculative result on the output.
- ST_CORRECT: correction cycle.
- ST_CORR_OUT: corrected result on the output.

The transitions are:

- accept_hit: ST_IDLE to ST_SPEC_OUT.
- accept_miss: ST_IDLE to ST_CORRECT.
- fix_done: ST_CORRECT to ST_CORR_OUT.
- take_spec: ST_SPEC_OUT to ST_IDLE when the result is consumed.
- take_corr: ST_CORR_OUT to ST_IDLE when the result is consumed.

Top module: `vlat_booth_mul`

## Requirements
- R1: Every presented product equals the two's-complement product of `in_a` and `in_b`, taken as signed N-bit values, over the full 2N bits. This includes most-negative times most-negative, zero and -1 operands.
- R2: When the estimate is right, `out_valid` and `out_spec_hit` are both 1 in the first cycle after the accepting clock edge.
- R3: When the estimate is wrong, `out_valid` is 0 in the first cycle after acceptance. `out_valid` is 1 with `out_spec_hit` 0 in the second cycle.
- R4: `in_ready` is 1 only in the idle state. It is 0 from acceptance until the result is taken, including the correction cycle. It is 1 again in the cycle after the result handshake.
- R5: The speculation hits exactly when the true and estimated carries are equal. Row r uses Booth digit -2*b[2r+1] + b[2r] + b[2r-1], with b[-1] = 0. The row value is digit*a, sign-extended to 2N bits and shifted left by 2r. The true carry is the sum over rows of bits [N-Z-1:0], shifted right by N-Z. The estimate is the sum over rows of bits [N-Z-1:N-Z-EST], shifted right by EST.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output holds `out_valid`, `out_prod` and `out_spec_hit` unchanged.
- R7: During and right after reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Block can accept operands |
| in_a | input | N | Signed multiplicand |
| in_b | input | N | Signed multiplier (Booth recoded) |
| out_valid | output | 1 | Product is presented |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 2N | Signed product |
| out_spec_hit | output | 1 | 1 when the one-cycle path produced the result |

## Verification
The assertions check the following on every cycle:

- Each presented product against a product captured at acceptance.
- That an accepted operation leads either to a hit result or to a correction cycle.
- That a correction cycle is always followed by an unflagged result.
- Output stability under backpressure.
- That `in_ready` is low whenever a result is pending.

Only the bench scenarios can show that the hit/miss choice follows the carry definition in R5 for each operand pair. The bench sweeps all operand pairs of a 6-bit, Z=1 configuration, with periodic output stalls.

// File: rtl/vlbm_pkg.sv
package vlbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SPEC_OUT = 2'd1,
        ST_CORRECT  = 2'd2,
        ST_CORR_OUT = 2'd3
    } vlbm_state_e;

    typedef enum logic [2:0] {
        DG_ZERO = 3'd0,
        DG_P1   = 3'd1,
        DG_P2   = 3'd2,
        DG_M1   = 3'd3,
        DG_M2   = 3'd4
    } booth_dig_e;

    function automatic booth_dig_e booth_decode(input logic [2:0] grp);
        booth_dig_e d;
        unique case (grp)
            3'b000, 3'b111: d = DG_ZERO;
            3'b001, 3'b010: d = DG_P1;
            3'b011:         d = DG_P2;
            3'b100:         d = DG_M2;
            3'b101, 3'b110: d = DG_M1;
            default:        d = DG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/booth_ppgen.sv
module booth_ppgen
    import vlbm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]               mcand,
    input  logic [N-1:0]               mplier,
    output logic [N/2-1:0][2*N-1:0]    pp
);
    localparam int ROWS = N / 2;
    localparam int PW   = 2 * N;

    logic [N:0]    mx;
    logic [PW-1:0] a_ext;

    assign mx    = {mplier, 1'b0};
    assign a_ext = {{N{mcand[N-1]}}, mcand};

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [2:0]    grp;
        logic [PW-1:0] row;

        assign grp = mx[2*r+2:2*r];

        always_comb begin
            unique case (booth_decode(grp))
                DG_P1:   row = a_ext;
                DG_P2:   row = a_ext << 1;
                DG_M1:   row = -a_ext;
                DG_M2:   row = -(a_ext << 1);
                default: row = '0;
            endcase
            pp[r] = row << (2 * r);
        end
    end

endmodule

// File: rtl/spec_accum.sv
module spec_accum #(
    parameter int N   = 8,
    parameter int Z   = 2,
    parameter int EST = 4,
    localparam int ROWS  = N / 2,
    localparam int LOW_W = N - Z,
    localparam int HI_W  = N + Z,
    localparam int CW    = $clog2(ROWS) + 1
) (
    input  logic [ROWS-1:0][2*N-1:0] pp,
    output logic [HI_W-1:0]          hi_spec,
    output logic [LOW_W-1:0]         lo_sum,
    output logic [CW-1:0]            delta
);
    localparam int LSW = LOW_W + CW;
    localparam int WW  = EST + CW;
    localparam int K   = LOW_W - EST;

    logic [LSW-1:0]  lo_acc;
    logic [WW-1:0]   win_acc;
    logic [HI_W-1:0] hi_acc;
    logic [CW-1:0]   c_true;
    logic [CW-1:0]   c_est;

    always_comb begin
        lo_acc  = '0;
        win_acc = '0;
        hi_acc  = '0;
        for (int r = 0; r < ROWS; r++) begin
            lo_acc  = lo_acc  + LSW'(pp[r][LOW_W-1:0]);
            win_acc = win_acc + WW'(pp[r][LOW_W-1:K]);
            hi_acc  = hi_acc  + pp[r][2*N-1:LOW_W];
        end
        c_true  = lo_acc[LSW-1:LOW_W];
        c_est   = win_acc[WW-1:EST];
        hi_spec = hi_acc + HI_W'(c_est);
        lo_sum  = lo_acc[LOW_W-1:0];
        delta   = c_true - c_est;
    end

endmodule

// File: rtl/vlat_booth_mul.sv
module vlat_booth_mul
    import vlbm_pkg::*;
#(
    parameter int N   = 8,
    parameter int Z   = 2,
    parameter int EST = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [N-1:0]   in_a,
    input  logic [N-1:0]   in_b,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [2*N-1:0] out_prod,
    output logic           out_spec_hit
);
    localparam int ROWS  = N / 2;
    localparam int LOW_W = N - Z;
    localparam int HI_W  = N + Z;
    localparam int CW    = $clog2(ROWS) + 1;

    vlbm_state_e state, nxt;

    logic [ROWS-1:0][2*N-1:0] pp;
    logic [HI_W-1:0]          hi_spec, hi_q;
    logic [LOW_W-1:0]         lo_sum, lo_q;
    logic [CW-1:0]            delta, delta_q;
    logic                     accept;

    booth_ppgen #(.N(N)) u_ppgen (
        .mcand  (in_a),
        .mplier (in_b),
        .pp     (pp)
    );

    spec_accum #(.N(N), .Z(Z), .EST(EST)) u_accum (
        .pp      (pp),
        .hi_spec (hi_spec),
        .lo_sum  (lo_sum),
        .delta   (delta)
    );

    assign accept = in_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (in_valid) nxt = (delta == '0) ? ST_SPEC_OUT : ST_CORRECT;
            ST_SPEC_OUT: if (out_ready) nxt = ST_IDLE;
            ST_CORRECT:  nxt = ST_CORR_OUT;
            ST_CORR_OUT: if (out_ready) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            delta_q <= '0;
        end else if (accept) begin
            hi_q    <= hi_spec;
            lo_q    <= lo_sum;
            delta_q <= delta;
        end else if (state == ST_CORRECT) begin
            hi_q    <= hi_q + HI_W'(delta_q);
        end
    end

    always_comb begin
        in_ready     = (state == ST_IDLE);
        out_valid    = (state == ST_SPEC_OUT) || (state == ST_CORR_OUT);
        out_spec_hit = (state == ST_SPEC_OUT);
        out_prod     = {hi_q, lo_q};
    end

endmodule

// File: rtl/vlat_booth_mul_chk.sv
module vlat_booth_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [N-1:0]   in_a,
    input logic [N-1:0]   in_b,
    input logic           out_valid,
    input logic           out_ready,
    input logic [2*N-1:0] out_prod,
    input logic           out_spec_hit
);
    logic [2*N-1:0] exp_q;
    logic signed [2*N-1:0] ea, eb;
    logic acc;

    assign acc = in_valid && in_ready;
    assign ea  = {{N{in_a[N-1]}}, in_a};
    assign eb  = {{N{in_b[N-1]}}, in_b};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   exp_q <= '0;
        else if (acc) exp_q <= ea * eb;
    end

    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod == exp_q); // R1
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((out_valid && out_spec_hit) || (!out_valid && !in_ready))); // R2
    AST_HIT_FLAG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_spec_hit |-> out_valid); // R2
    AST_CORR_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_valid) |=> (out_valid && !out_spec_hit)); // R3
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_prod) && $stable(out_spec_hit))); // R6

endmodule

bind vlat_booth_mul vlat_booth_mul_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_a         (in_a),
    .in_b         (in_b),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_prod     (out_prod),
    .out_spec_hit (out_spec_hit)
);

// File: tb/vlat_booth_mul_tb_top.sv
`timescale 1ns/1ps
module vlat_booth_mul_tb_top;
    localparam int N     = 6;
    localparam int Z     = 1;
    localparam int EST   = 4;
    localparam int LOW_W = N - Z;
    localparam int PW    = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b1;
    logic [N-1:0] in_a = '0, in_b = '0;
    logic in_ready, out_valid, out_spec_hit;
    logic [PW-1:0] out_prod;

    int n_chk = 0, n_fail = 0, n_hit = 0, n_ops = 0, cyc = 0;

    always #4 clk = ~clk;

    vlat_booth_mul #(.N(N), .Z(Z), .EST(EST)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_prod(out_prod), .out_spec_hit(out_spec_hit)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5: hit iff true low-part carry equals the windowed estimate
    function automatic bit exp_hit(input int a, input int b);
        int lo_tot = 0, win_tot = 0;
        for (int r = 0; r < N / 2; r++) begin
            int bm1 = (r == 0) ? 0 : ((b >> (2*r-1)) & 1);
            int d = -2 * ((b >> (2*r+1)) & 1) + ((b >> (2*r)) & 1) + bm1;
            logic [PW-1:0] row = PW'(longint'(d * a) << (2*r));
            lo_tot  += int'(row[LOW_W-1:0]);
            win_tot += int'(row[LOW_W-1:LOW_W-EST]);
        end
        return (lo_tot >> LOW_W) == (win_tot >> EST);
    endfunction

    task automatic run_op(input int a, input int b, input bit stall);
        logic [PW-1:0] ep = PW'(longint'(a * b));
        bit hit = exp_hit(a, b);
        @(negedge clk);
        in_a = N'(a); in_b = N'(b); in_valid = 1'b1; out_ready = !stall;
        @(negedge clk);
        in_valid = 1'b0;
        n_ops++;
        if (hit) begin
            n_hit++;
            chk(out_valid && out_spec_hit, "R2 hit latency", {out_valid, out_spec_hit}, 2'b11);
        end else begin
            chk(!out_valid && !in_ready, "R3/R4 correction cycle", {out_valid, in_ready}, 2'b00);
            @(negedge clk);
            chk(out_valid && !out_spec_hit, "R3 miss latency", {out_valid, out_spec_hit}, 2'b10);
        end
        chk(out_prod == ep, "R1 product", out_prod, ep);
        chk(!in_ready, "R4 busy", in_ready, 0);
        if (stall) begin
            repeat (2) begin
                @(negedge clk);
                chk(out_valid && out_prod == ep && out_spec_hit == hit, "R6 hold", out_prod, ep);
            end
            out_ready = 1'b1;
        end
        @(negedge clk);
        chk(in_ready && !out_valid, "R4 idle after take", {in_ready, out_valid}, 2'b10);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid, "R7 reset", {in_ready, out_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R7 after reset", {in_ready, out_valid}, 2'b10);
        // R1 corners: most-negative squared, zero, -1
        run_op(-(1 << (N-1)), -(1 << (N-1)), 1'b0);
        run_op(0, -(1 << (N-1)), 1'b0);
        run_op(-1, -1, 1'b1);
        run_op(-1, (1 << (N-1)) - 1, 1'b0);
        for (int a = -(1 << (N-1)); a < (1 << (N-1)); a++)
            for (int b = -(1 << (N-1)); b < (1 << (N-1)); b++)
                run_op(a, b, ((a * 7 + b) % 37) == 0);
        $display("speculation hits: %0d of %0d", n_hit, n_ops);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule